// File: doc/BRIEF.md
# Memory-Access Stage with Store-to-Load Forwarding

This block is the memory-access stage of a small in-order pipeline. An instruction enters from the execute stage and is captured in an execute-to-memory pipeline register. From that point it drives a word-addressed data memory. The memory reads combinationally from the registered address. Every input the memory sees comes out of a register, so nothing bypasses the pipeline register.

A store is posted. Its address and data go into a one-entry record at the end of the store's memory cycle, and the memory is written from that record on the following clock edge. The write therefore lands one cycle after the store leaves. A load in the very next slot would read a stale word. A comparator detects that case: the previous memory-stage instruction was a valid store, the current one is a valid load, and their word indexes are equal. When this happens, the recorded store data replaces the memory read. The load result is available combinationally, and a registered memory-to-writeback copy carries it on to the next stage.

Top module: `mem_stage`

## Requirements
- R1: While `rst` is high no memory write takes place, and `wb_valid` and `wb_load` read 0 one cycle later. Words stored before reset keep their values after it.
- R2: A valid load that does not directly follow a store returns on `ld_data` the last word stored at its index, in the cycle it occupies the stage.
- R3: The memory index is address bits [9:2]. The two low address bits are ignored. Addresses that differ only above bit 9 select the same word, both for memory access and for the forwarding comparison.
- R4: When a valid load directly follows a valid store with the same index, `ld_data` equals the store's write data. The memory read is not used.
- R5: When a valid load directly follows a valid store with a different index, `ld_data` is the memory word at the load's index and not the store data.
- R6: An instruction with `ex_valid` low writes nothing, whatever its store bit says, and takes no part in forwarding. It also leaves `wb_valid` low one cycle later.
- R7: An instruction with both `ex_load` and `ex_store` set is executed as a store only. Its `wb_load` is 0, and a later load of its index returns its data.
- R8: With two stores in a row to one index, the second store's data wins. This holds both for a load that directly follows the pair and for a load issued later.
- R9: One cycle after an instruction occupies the stage, `wb_valid`, `wb_load` and `wb_dest` repeat its valid bit, load bit and destination tag. `wb_data` holds the load result for a load and the address otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ex_valid | input | 1 | Instruction from execute is real (0 = bubble) |
| ex_load | input | 1 | Instruction reads data memory |
| ex_store | input | 1 | Instruction writes data memory |
| ex_addr | input | 32 | Byte address computed in execute |
| ex_wdata | input | 32 | Store operand, already register-forwarded |
| ex_dest | input | 5 | Destination register tag |
| ld_data | output | 32 | Load result of the instruction now in the stage |
| wb_valid | output | 1 | Registered valid bit toward writeback |
| wb_load | output | 1 | Registered load bit toward writeback |
| wb_dest | output | 5 | Registered destination tag |
| wb_data | output | 32 | Registered load result or address |

## Verification
The main target is a store followed at once by a load to the same word. A design without the comparator, or one that compares in the wrong cycle, returns the old memory word there. The bench also pairs a store with a load to a different word, which catches a comparator that forwards too eagerly. It exercises aliased addresses, where a full-width compare would miss a match, and back-to-back stores, where a design that keeps the older record would hand out the first value. Bubbles that carry a stray store bit, instructions with both control bits set, and stores presented during reset are each followed by a load of the same word. These catch a write enable that ignores the valid bit or the reset.

// File: rtl/mem_stage_pkg.sv
package mem_stage_pkg;

  typedef struct packed {
    logic valid;
    logic load;
    logic store;
  } stage_ctrl_t;

  localparam stage_ctrl_t CTRL_IDLE = '{valid: 1'b0, load: 1'b0, store: 1'b0};

endpackage

// File: rtl/exmem_reg.sv
module exmem_reg
  import mem_stage_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_load,
  input  logic              in_store,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic [TAG_W-1:0]  in_dest,
  output stage_ctrl_t       q_ctrl,
  output logic [ADDR_W-1:0] q_addr,
  output logic [DATA_W-1:0] q_wdata,
  output logic [TAG_W-1:0]  q_dest
);

  // Control bits reset so that no access can start; datapath bits need none.
  always_ff @(posedge clk) begin
    if (rst) begin
      q_ctrl <= CTRL_IDLE;
    end else begin
      q_ctrl.valid <= in_valid;
      q_ctrl.store <= in_valid & in_store;
      // One access per instruction: a store bit overrides a load bit.
      q_ctrl.load  <= in_valid & in_load & ~in_store;
    end
  end

  always_ff @(posedge clk) begin
    q_addr  <= in_addr;
    q_wdata <= in_wdata;
    q_dest  <= in_dest;
  end

  AST_SINGLE_ACCESS: assert property (@(posedge clk) disable iff (rst)
    !(q_ctrl.load && q_ctrl.store)) else $error("load and store together"); // R7

  AST_BUBBLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !q_ctrl.valid |-> !q_ctrl.load && !q_ctrl.store) else $error("bubble with control"); // R6

endmodule

// File: rtl/store_fwd.sv
module store_fwd #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cur_valid,
  input  logic              cur_load,
  input  logic              cur_store,
  input  logic [IDX_W-1:0]  cur_idx,
  input  logic [DATA_W-1:0] cur_wdata,
  output logic              rec_valid,
  output logic [IDX_W-1:0]  rec_idx,
  output logic [DATA_W-1:0] rec_data,
  output logic              hit
);

  // One-entry record of the store that just left the stage. Any other
  // instruction (bubbles included) empties it.
  always_ff @(posedge clk) begin
    if (rst) begin
      rec_valid <= 1'b0;
    end else begin
      rec_valid <= cur_valid & cur_store;
    end
  end

  always_ff @(posedge clk) begin
    rec_idx  <= cur_idx;
    rec_data <= cur_wdata;
  end

  always_comb begin
    hit = rec_valid & cur_valid & cur_load & (rec_idx == cur_idx);
  end

  AST_HIT_AFTER_STORE: assert property (@(posedge clk) disable iff (rst)
    hit |-> $past(cur_valid && cur_store)) else $error("forward without prior store"); // R4

  AST_HIT_SAME_INDEX: assert property (@(posedge clk) disable iff (rst)
    hit |-> cur_idx == $past(cur_idx)) else $error("forward index mismatch"); // R3

endmodule

// File: rtl/word_ram.sv
module word_ram #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Clocked write port; contents are never reset.
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // Combinational read port.
  assign rdata = mem[raddr];

endmodule

// File: rtl/memwb_reg.sv
module memwb_reg #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              d_valid,
  input  logic              d_load,
  input  logic [TAG_W-1:0]  d_dest,
  input  logic [DATA_W-1:0] d_data,
  output logic              q_valid,
  output logic              q_load,
  output logic [TAG_W-1:0]  q_dest,
  output logic [DATA_W-1:0] q_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_load  <= 1'b0;
    end else begin
      q_valid <= d_valid;
      q_load  <= d_load;
    end
  end

  always_ff @(posedge clk) begin
    q_dest <= d_dest;
    q_data <= d_data;
  end

  AST_WB_TRACKS_VALID: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> q_valid == $past(d_valid)) else $error("wb valid lost"); // R9

endmodule

// File: rtl/mem_stage.sv
module mem_stage
  import mem_stage_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 5,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ex_valid,
  input  logic              ex_load,
  input  logic              ex_store,
  input  logic [ADDR_W-1:0] ex_addr,
  input  logic [DATA_W-1:0] ex_wdata,
  input  logic [TAG_W-1:0]  ex_dest,
  output logic [DATA_W-1:0] ld_data,
  output logic              wb_valid,
  output logic              wb_load,
  output logic [TAG_W-1:0]  wb_dest,
  output logic [DATA_W-1:0] wb_data
);

  localparam int IDX_LO = 2;
  localparam int IDX_HI = IDX_LO + IDX_W - 1;

  stage_ctrl_t       m_ctrl;
  logic [ADDR_W-1:0] m_addr;
  logic [DATA_W-1:0] m_wdata;
  logic [TAG_W-1:0]  m_dest;
  logic [IDX_W-1:0]  m_idx;

  logic              rec_valid;
  logic [IDX_W-1:0]  rec_idx;
  logic [DATA_W-1:0] rec_data;
  logic              fwd_hit;
  logic [DATA_W-1:0] ram_rdata;
  logic [DATA_W-1:0] wb_next;

  exmem_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_exmem (
    .clk      (clk),
    .rst      (rst),
    .in_valid (ex_valid),
    .in_load  (ex_load),
    .in_store (ex_store),
    .in_addr  (ex_addr),
    .in_wdata (ex_wdata),
    .in_dest  (ex_dest),
    .q_ctrl   (m_ctrl),
    .q_addr   (m_addr),
    .q_wdata  (m_wdata),
    .q_dest   (m_dest)
  );

  assign m_idx = m_addr[IDX_HI:IDX_LO];

  store_fwd #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_fwd (
    .clk       (clk),
    .rst       (rst),
    .cur_valid (m_ctrl.valid),
    .cur_load  (m_ctrl.load),
    .cur_store (m_ctrl.store),
    .cur_idx   (m_idx),
    .cur_wdata (m_wdata),
    .rec_valid (rec_valid),
    .rec_idx   (rec_idx),
    .rec_data  (rec_data),
    .hit       (fwd_hit)
  );

  // The posted store is written from the record, one edge after it left.
  word_ram #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_ram (
    .clk   (clk),
    .we    (rec_valid),
    .waddr (rec_idx),
    .wdata (rec_data),
    .raddr (m_idx),
    .rdata (ram_rdata)
  );

  always_comb begin
    ld_data = fwd_hit ? rec_data : ram_rdata;
    wb_next = m_ctrl.load ? ld_data : m_addr;
  end

  memwb_reg #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_memwb (
    .clk     (clk),
    .rst     (rst),
    .d_valid (m_ctrl.valid),
    .d_load  (m_ctrl.load),
    .d_dest  (m_dest),
    .d_data  (wb_next),
    .q_valid (wb_valid),
    .q_load  (wb_load),
    .q_dest  (wb_dest),
    .q_data  (wb_data)
  );

  AST_NO_WRITE_AFTER_RESET: assert property (@(posedge clk)
    rst |=> !rec_valid) else $error("write armed during reset"); // R1

  AST_WRITE_FROM_STORE: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> $past(m_ctrl.valid && m_ctrl.store)) else $error("write without store"); // R6

  AST_FWD_DATA: assert property (@(posedge clk) disable iff (rst)
    fwd_hit |-> ld_data == $past(m_wdata)) else $error("forwarded data wrong"); // R4

endmodule

// File: tb/test_mem_stage.sv
module test_mem_stage;

  logic        clk = 1'b0;
  logic        rst;
  logic        ex_valid, ex_load, ex_store;
  logic [31:0] ex_addr, ex_wdata;
  logic [4:0]  ex_dest;
  logic [31:0] ld_data, wb_data;
  logic        wb_valid, wb_load;
  logic [4:0]  wb_dest;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  mem_stage i_mem_stage (
    .clk(clk), .rst(rst), .ex_valid(ex_valid), .ex_load(ex_load),
    .ex_store(ex_store), .ex_addr(ex_addr), .ex_wdata(ex_wdata),
    .ex_dest(ex_dest), .ld_data(ld_data), .wb_valid(wb_valid),
    .wb_load(wb_load), .wb_dest(wb_dest), .wb_data(wb_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge, with the
  // instruction sitting in the stage.
  task automatic issue(input logic v, input logic l, input logic s,
                       input logic [31:0] a, input logic [31:0] d, input logic [4:0] t);
    ex_valid = v; ex_load = l; ex_store = s;
    ex_addr = a; ex_wdata = d; ex_dest = t;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bubble();
    issue(1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 5'd0);
  endtask

  task automatic st(input logic [31:0] a, input logic [31:0] d);
    issue(1'b1, 1'b0, 1'b1, a, d, 5'd0);
  endtask

  task automatic ld(input logic [31:0] a, input logic [4:0] t);
    issue(1'b1, 1'b1, 1'b0, a, 32'h0, t);
  endtask

  task automatic t_reset();
    st(32'h0000_0010, 32'hAAAA_0001);
    bubble();
    rst = 1'b1;
    st(32'h0000_0010, 32'hBBBB_0002);
    st(32'h0000_0010, 32'hBBBB_0003);
    check("R1 wb_valid in reset", {31'd0, wb_valid}, 32'd0);
    check("R1 wb_load in reset", {31'd0, wb_load}, 32'd0);
    rst = 1'b0;
    bubble();
    ld(32'h0000_0010, 5'd1);
    check("R1 memory kept across reset", ld_data, 32'hAAAA_0001);
  endtask

  task automatic t_plain_load();
    st(32'h0000_0100, 32'h1111_2222);
    bubble();
    ld(32'h0000_0100, 5'd2);
    check("R2 load after gap", ld_data, 32'h1111_2222);
  endtask

  task automatic t_forward();
    st(32'h0000_0020, 32'h0000_00F0);
    bubble();
    st(32'h0000_0020, 32'hCAFE_0001);
    ld(32'h0000_0020, 5'd3);
    check("R4 store then load same word", ld_data, 32'hCAFE_0001);
  endtask

  task automatic t_no_forward();
    st(32'h0000_0040, 32'h4040_4040);
    bubble();
    st(32'h0000_0044, 32'hDEAD_0044);
    ld(32'h0000_0040, 5'd4);
    check("R5 store then load other word", ld_data, 32'h4040_4040);
  endtask

  task automatic t_alias();
    st(32'h0000_0030, 32'h0000_0001);
    bubble();
    st(32'h0000_0433, 32'h5A5A_0433);
    ld(32'h0000_0031, 5'd5);
    check("R3 aliased forward", ld_data, 32'h5A5A_0433);
    bubble();
    ld(32'hFFFF_F032, 5'd5);
    check("R3 aliased memory read", ld_data, 32'h5A5A_0433);
  endtask

  task automatic t_bubble();
    st(32'h0000_0050, 32'h0505_0505);
    bubble();
    issue(1'b0, 1'b0, 1'b1, 32'h0000_0050, 32'h9999_9999, 5'd6);
    bubble();
    check("R6 bubble wb_valid", {31'd0, wb_valid}, 32'd0);
    ld(32'h0000_0050, 5'd6);
    check("R6 bubble store ignored", ld_data, 32'h0505_0505);
  endtask

  task automatic t_both_bits();
    issue(1'b1, 1'b1, 1'b1, 32'h0000_0060, 32'h6060_6060, 5'd7);
    bubble();
    check("R7 wb_load low", {31'd0, wb_load}, 32'd0);
    ld(32'h0000_0060, 5'd7);
    check("R7 treated as store", ld_data, 32'h6060_6060);
  endtask

  task automatic t_two_stores();
    st(32'h0000_0070, 32'h7000_0001);
    st(32'h0000_0070, 32'h7000_0002);
    ld(32'h0000_0070, 5'd8);
    check("R8 newest store forwarded", ld_data, 32'h7000_0002);
    bubble();
    ld(32'h0000_0070, 5'd8);
    check("R8 newest store in memory", ld_data, 32'h7000_0002);
  endtask

  task automatic t_writeback();
    st(32'h0000_0080, 32'h8888_0000);
    st(32'h0000_0080, 32'h8888_1234);
    ld(32'h0000_0080, 5'd9);
    issue(1'b1, 1'b0, 1'b0, 32'h1234_5678, 32'h0, 5'd10);
    check("R9 wb_valid", {31'd0, wb_valid}, 32'd1);
    check("R9 wb_load", {31'd0, wb_load}, 32'd1);
    check("R9 wb_dest", {27'd0, wb_dest}, 32'd9);
    check("R9 wb_data load", wb_data, 32'h8888_1234);
    bubble();
    check("R9 wb_load nonload", {31'd0, wb_load}, 32'd0);
    check("R9 wb_data address", wb_data, 32'h1234_5678);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    ex_valid = 1'b0; ex_load = 1'b0; ex_store = 1'b0;
    ex_addr = '0; ex_wdata = '0; ex_dest = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset wb_valid", {31'd0, wb_valid}, 32'd0);
    check("R1 reset wb_load", {31'd0, wb_load}, 32'd0);
    rst = 1'b0;
    t_reset();
    t_plain_load();
    t_forward();
    t_no_forward();
    t_alias();
    t_bubble();
    t_both_bits();
    t_two_stores();
    t_writeback();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule